// File: doc/BRIEF.md
# Three-of-Eighteen Ranked Candidate Sorter

The block is given eighteen candidate words on every clock cycle. Nine sources supply them, two slots per source. It picks the three highest-ranked candidates and presents them on three output positions, best first. A 4-bit quality field in each word sets the rank. A quality of zero marks an empty slot, and an empty slot never takes part. Equal qualities are resolved by a fixed order on the source and slot indices, so a given input set always produces the same result.

A 9-bit winner vector goes out with the three outputs. It has one bit per source, and that bit tells the source whether any of its candidates was selected. The block is a three-register pipeline that accepts a new set on every cycle. Each stage register is updated by its own next-value process, kept apart from the combinational logic that feeds it:

- **Capture stage:** registers the words and the occupied flags.
- **Rank stage:** registers the rank of every candidate.
- **Pick stage:** registers the three output positions, their valid flags and the winner vector.

Top module: `msort_top3`

## Requirements
- R1: Candidate c = 2·n + s (source n in 0..8, slot s in 0..1) occupies `cand_in[c*32 +: 32]`. Its quality is bits [31:28] of the word. A quality of 0 marks the slot as empty, and an empty slot is never selected.
- R2: Among the non-empty candidates of a set, the outputs hold exactly the three highest-ranked ones, with each full word passed through unchanged.
- R3: Position 0 (`best_word[31:0]`) holds the best candidate, position 1 (`[63:32]`) the second and position 2 (`[95:64]`) the third. Quality never increases from one occupied position to the next.
- R4: Between candidates of equal quality, the lower source index ranks higher. Within one source, slot 0 ranks above slot 1.
- R5: The result for the set sampled on a rising edge appears on the outputs just after the third rising edge, counting that one. A new set is accepted on every edge.
- R6: When fewer than three candidates are non-empty, each unused position outputs all zeros with its `best_vld` bit clear. The valid bits always fill from position 0 upward.
- R7: `src_win[n]` is 1 exactly when a candidate of source n is among the occupied output positions. It is aligned with those outputs.
- R8: While `rst_n` is low, `best_word`, `best_vld` and `src_win` are all zero, whatever the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one candidate set per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cand_in | input | 576 | Eighteen 32-bit candidate words, indexed by 2·source + slot |
| best_word | output | 96 | Three selected words, position 0 in the low 32 bits |
| best_vld | output | 3 | Occupied flag for each output position |
| src_win | output | 9 | Per-source selected flag |

## Verification
The pipeline keeps no state beyond the three stages, so any internal fault shows up within three cycles of the set it touches and is gone one cycle later. A wrong rank value causes a duplicated, missing or misordered output word, or a winner bit that points at a source with no word among the outputs. These symptoms appear on the outputs of exactly that set. Sets full of equal qualities and sets with fewer than three occupied slots expose faults in the tie order and in the handling of empty positions, which random data seldom reaches.

// File: rtl/msort_pkg.sv
package msort_pkg;
    localparam int MS_SRC_N   = 9;
    localparam int MS_SLOT_N  = 2;
    localparam int MS_WORD_W  = 32;
    localparam int MS_QUAL_W  = 4;
    localparam int MS_PICK_N  = 3;
endpackage

// File: rtl/msort_capture.sv
module msort_capture #(
    parameter int CAND_N = 18,
    parameter int WORD_W = 32,
    parameter int QUAL_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CAND_N*WORD_W-1:0] words_i,
    output logic [CAND_N*WORD_W-1:0] words_q,
    output logic [CAND_N-1:0]        occ_q
);
    logic [CAND_N-1:0] occ_d;

    always_comb begin
        for (int c = 0; c < CAND_N; c++) begin
            occ_d[c] = |words_i[c*WORD_W + WORD_W - 1 -: QUAL_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_q <= '0;
            occ_q   <= '0;
        end else begin
            words_q <= words_i;
            occ_q   <= occ_d;
        end
    end
endmodule

// File: rtl/msort_rank.sv
module msort_rank #(
    parameter int CAND_N = 18,
    parameter int WORD_W = 32,
    parameter int QUAL_W = 4,
    localparam int RANK_W = $clog2(CAND_N)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CAND_N*WORD_W-1:0] words_i,
    input  logic [CAND_N-1:0]        occ_i,
    output logic [CAND_N*WORD_W-1:0] words_q,
    output logic [CAND_N-1:0]        occ_q,
    output logic [RANK_W-1:0]        rank_q [CAND_N]
);
    logic [QUAL_W-1:0] qual   [CAND_N];
    logic [RANK_W-1:0] rank_d [CAND_N];

    for (genvar g = 0; g < CAND_N; g++) begin : g_qual
        assign qual[g] = words_i[g*WORD_W + WORD_W - 1 -: QUAL_W];
    end

    // Rank = number of occupied candidates that beat this one; the order is
    // total (quality, then lower index), so occupied ranks are distinct.
    always_comb begin
        for (int i = 0; i < CAND_N; i++) begin
            rank_d[i] = '0;
            for (int j = 0; j < CAND_N; j++) begin
                if (j != i && occ_i[j]) begin
                    if (qual[j] > qual[i] || (qual[j] == qual[i] && j < i)) begin
                        rank_d[i] = rank_d[i] + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_q <= '0;
            occ_q   <= '0;
            for (int i = 0; i < CAND_N; i++) rank_q[i] <= '0;
        end else begin
            words_q <= words_i;
            occ_q   <= occ_i;
            for (int i = 0; i < CAND_N; i++) rank_q[i] <= rank_d[i];
        end
    end
endmodule

// File: rtl/msort_pick.sv
module msort_pick #(
    parameter int SRC_N  = 9,
    parameter int SLOT_N = 2,
    parameter int WORD_W = 32,
    parameter int PICK_N = 3,
    localparam int CAND_N = SRC_N * SLOT_N,
    localparam int RANK_W = $clog2(CAND_N)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CAND_N*WORD_W-1:0] words_i,
    input  logic [CAND_N-1:0]        occ_i,
    input  logic [RANK_W-1:0]        rank_i [CAND_N],
    output logic [PICK_N*WORD_W-1:0] pick_q,
    output logic [PICK_N-1:0]        pick_vld_q,
    output logic [SRC_N-1:0]         win_q
);
    localparam logic [RANK_W-1:0] PICK_LIM = RANK_W'(PICK_N);

    logic [PICK_N*WORD_W-1:0] pick_d;
    logic [PICK_N-1:0]        pick_vld_d;
    logic [SRC_N-1:0]         win_d;
    logic [CAND_N-1:0]        chosen;

    always_comb begin
        pick_d     = '0;
        pick_vld_d = '0;
        for (int p = 0; p < PICK_N; p++) begin
            for (int i = 0; i < CAND_N; i++) begin
                if (occ_i[i] && rank_i[i] == RANK_W'(p)) begin
                    pick_d[p*WORD_W +: WORD_W] = pick_d[p*WORD_W +: WORD_W]
                                               | words_i[i*WORD_W +: WORD_W];
                    pick_vld_d[p] = 1'b1;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < CAND_N; i++) begin
            chosen[i] = occ_i[i] && (rank_i[i] < PICK_LIM);
        end
        for (int n = 0; n < SRC_N; n++) begin
            win_d[n] = |chosen[n*SLOT_N +: SLOT_N];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pick_q     <= '0;
            pick_vld_q <= '0;
            win_q      <= '0;
        end else begin
            pick_q     <= pick_d;
            pick_vld_q <= pick_vld_d;
            win_q      <= win_d;
        end
    end
endmodule

// File: rtl/msort_top3.sv
module msort_top3
    import msort_pkg::*;
#(
    parameter int SRC_N  = MS_SRC_N,
    parameter int SLOT_N = MS_SLOT_N,
    parameter int WORD_W = MS_WORD_W,
    parameter int QUAL_W = MS_QUAL_W,
    parameter int PICK_N = MS_PICK_N,
    localparam int CAND_N = SRC_N * SLOT_N,
    localparam int RANK_W = $clog2(CAND_N)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CAND_N*WORD_W-1:0] cand_in,
    output logic [PICK_N*WORD_W-1:0] best_word,
    output logic [PICK_N-1:0]        best_vld,
    output logic [SRC_N-1:0]         src_win
);
    logic [CAND_N*WORD_W-1:0] cap_words;
    logic [CAND_N-1:0]        cap_occ;
    logic [CAND_N*WORD_W-1:0] rk_words;
    logic [CAND_N-1:0]        rk_occ;
    logic [RANK_W-1:0]        rk_rank [CAND_N];

    msort_capture #(.CAND_N(CAND_N), .WORD_W(WORD_W), .QUAL_W(QUAL_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .words_i(cand_in),
        .words_q(cap_words), .occ_q(cap_occ)
    );

    msort_rank #(.CAND_N(CAND_N), .WORD_W(WORD_W), .QUAL_W(QUAL_W)) u_rank (
        .clk(clk), .rst_n(rst_n), .words_i(cap_words), .occ_i(cap_occ),
        .words_q(rk_words), .occ_q(rk_occ), .rank_q(rk_rank)
    );

    msort_pick #(.SRC_N(SRC_N), .SLOT_N(SLOT_N), .WORD_W(WORD_W), .PICK_N(PICK_N)) u_pick (
        .clk(clk), .rst_n(rst_n), .words_i(rk_words), .occ_i(rk_occ),
        .rank_i(rk_rank), .pick_q(best_word), .pick_vld_q(best_vld), .win_q(src_win)
    );
endmodule

// File: rtl/msort_top3_chk.sv
module msort_top3_chk #(
    parameter int SRC_N  = 9,
    parameter int SLOT_N = 2,
    parameter int WORD_W = 32,
    parameter int QUAL_W = 4,
    parameter int PICK_N = 3,
    localparam int CAND_N = SRC_N * SLOT_N
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [CAND_N*WORD_W-1:0] cand_in,
    input logic [PICK_N*WORD_W-1:0] best_word,
    input logic [PICK_N-1:0]        best_vld,
    input logic [SRC_N-1:0]         src_win
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (!rst_n)           age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R5: an all-empty set yields no occupied position three edges later
    a_r5_empty_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && $past(cand_in == '0, 3)) |-> best_vld == '0);

    // R7: a winner flag needs at least one occupied output
    a_r7_win_needs_output: assert property (@(posedge clk) disable iff (!rst_n)
        (src_win != '0) |-> best_vld[0]);

    // R7: no more flagged sources than occupied positions
    a_r7_win_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(src_win) <= $countones(best_vld));

    for (genvar p = 0; p < PICK_N; p++) begin : g_pos
        // R6: an unused position is all zero
        a_r6_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !best_vld[p] |-> best_word[p*WORD_W +: WORD_W] == '0);
        // R1: an occupied position never carries a zero quality
        a_r1_no_empty_pick: assert property (@(posedge clk) disable iff (!rst_n)
            best_vld[p] |-> best_word[p*WORD_W + WORD_W - 1 -: QUAL_W] != '0);
        if (p > 0) begin : g_pair
            // R6: valid flags fill from position 0
            a_r6_prefix: assert property (@(posedge clk) disable iff (!rst_n)
                best_vld[p] |-> best_vld[p-1]);
            // R3: quality does not rise toward later positions
            a_r3_descending: assert property (@(posedge clk) disable iff (!rst_n)
                best_vld[p] |-> best_word[(p-1)*WORD_W + WORD_W - 1 -: QUAL_W]
                             >= best_word[p*WORD_W + WORD_W - 1 -: QUAL_W]);
        end
    end
endmodule

bind msort_top3 msort_top3_chk #(
    .SRC_N(SRC_N), .SLOT_N(SLOT_N), .WORD_W(WORD_W), .QUAL_W(QUAL_W), .PICK_N(PICK_N)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cand_in(cand_in),
    .best_word(best_word), .best_vld(best_vld), .src_win(src_win)
);

// File: tb/msort_top3_bench.sv
module msort_top3_bench;
    localparam int NC = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [575:0]  cand_in = '0;
    logic [95:0]   best_word;
    logic [2:0]    best_vld;
    logic [8:0]    src_win;

    int checks = 0;
    int errors = 0;
    logic [575:0] hist [3];

    msort_top3 u_msort_top3 (
        .clk(clk), .rst_n(rst_n), .cand_in(cand_in),
        .best_word(best_word), .best_vld(best_vld), .src_win(src_win)
    );

    always #10 clk = ~clk;

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Reference: repeatedly take the first strictly better unused candidate.
    task automatic ref_top(input logic [575:0] s, output logic [95:0] w,
                           output logic [2:0] v, output logic [8:0] win);
        logic [NC-1:0] used = '0;
        w = '0; v = '0; win = '0;
        for (int k = 0; k < 3; k++) begin
            int best = -1;
            for (int i = 0; i < NC; i++) begin
                if (s[i*32+28 +: 4] != 0 && !used[i]) begin
                    if (best < 0 || s[i*32+28 +: 4] > s[best*32+28 +: 4]) best = i;
                end
            end
            if (best >= 0) begin
                used[best] = 1'b1;
                w[k*32 +: 32] = s[best*32 +: 32];
                v[k] = 1'b1;
                win[best/2] = 1'b1;
            end
        end
    endtask

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: check the set from three steps back, then drive the next.
    task automatic step(input logic [575:0] s, input string tag);
        logic [95:0] ew; logic [2:0] ev; logic [8:0] ewin;
        ref_top(hist[2], ew, ev, ewin);
        chk({tag, " R2/R3/R4 words"}, best_word, ew);
        chk({tag, " R6 valid"}, {93'd0, best_vld}, {93'd0, ev});
        chk({tag, " R7 winners"}, {87'd0, src_win}, {87'd0, ewin});
        hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = s;
        cand_in = s;
        @(negedge clk);
    endtask

    function automatic logic [31:0] mk(input logic [3:0] q, input logic [27:0] pay);
        return {q, pay};
    endfunction

    function automatic logic [575:0] rnd_set(input int zero_pct, input int qmax);
        logic [575:0] s;
        for (int i = 0; i < NC; i++) begin
            logic [3:0] q;
            q = ($urandom_range(99) < zero_pct) ? 4'd0 : 4'($urandom_range(qmax, 1));
            s[i*32 +: 32] = mk(q, 28'($urandom));
        end
        return s;
    endfunction

    initial begin
        logic [575:0] s;
        void'($urandom(32'h5EED_0123));
        for (int i = 0; i < 3; i++) hist[i] = '0;
        // R8: reset holds outputs at zero with busy inputs
        cand_in = rnd_set(0, 15);
        repeat (4) @(negedge clk);
        chk("R8 reset words", best_word, '0);
        chk("R8 reset valid", {93'd0, best_vld}, '0);
        chk("R8 reset winners", {87'd0, src_win}, '0);
        cand_in = '0;
        rst_n = 1'b1;
        @(negedge clk);

        step('0, "empty set R6");
        s = '0; s[17*32 +: 32] = mk(4'd3, 28'h0ABCDEF);
        step(s, "single source8 slot1 R1 R6");
        s = '0; s[4*32 +: 32] = mk(4'd2, 28'h1); s[9*32 +: 32] = mk(4'd9, 28'h2);
        step(s, "two valid R6");
        s = '0; for (int i = 0; i < NC; i++) s[i*32 +: 32] = mk(4'd5, 28'(i + 100));
        step(s, "all tied R4");
        s[9*32 +: 32] = mk(4'd6, 28'h77);
        step(s, "tied plus source4 slot1 ahead R4");
        s = '0; for (int i = 0; i < NC; i++) s[i*32 +: 32] = mk(4'd15, 28'(i));
        s[0 +: 32] = mk(4'd14, 28'h5);
        step(s, "max quality R2 R4");
        s = '0; s[16*32 +: 32] = mk(4'd7, 28'hF); s[17*32 +: 32] = mk(4'd7, 28'hE);
        s[2*32 +: 32] = mk(4'd0, 28'hFFFFFFF);
        step(s, "empty with payload R1");
        for (int n = 0; n < 400; n++) begin
            step(rnd_set(n % 100, (n % 3 == 0) ? 2 : 15), "random R2 R3 R4 R5 R7");
        end
        for (int n = 0; n < 3; n++) step('0, "flush R5");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule